// File: doc/BRIEF.md
# Overflow Event Timer with Posted Register Writes

This block is an up-counting timer that serves as a one-shot or periodic event source and as a free-running cycle counter. Software programs it over a simple register bus clocked by the bus clock, while the counter itself runs on a separate, usually slower, functional clock. The counter advances by one on every functional tick while running. When it steps past the all-ones value it raises an overflow event. It then either reloads from a reload register or stops.

A delay of N ticks is programmed by writing all-ones minus N into the counter. The counter width therefore sets the longest delay. The writes to the control, reload and counter registers are posted. Each one is accepted at once on the bus side and handed to the functional domain by a toggle handshake. A per-register pending bit is set while the handoff is in flight. Because of the handshake, a posted write takes a few functional ticks to land, which sets a minimum useful delay of about three ticks.

The counter value and the live run state are copied back to the bus domain all the time, so software can read the count while the timer runs.

Top module: `ovf_timer`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: While running, the counter advances by one per functional tick. Once a stop (CTRL bit0 = 0) has landed, the count holds its value, and stopping leaves the overflow status unchanged.
- R3: A counter loaded with all-ones minus N and then started overflows N+1 ticks after the start lands. The overflow sets the status bit (address 4, bit0). Seen from the bus, `irq` rises between N+1 and N+8 functional ticks after the start write.
- R4: When the counter overflows with auto-reload set (CTRL bit1 = 1), it reloads from LOAD (address 1) and keeps running. Without auto-reload it wraps to zero and clears its run state.
- R5: CTRL (address 0), LOAD (address 1) and COUNT (address 2) are posted. Accepting a write sets the PEND bit (address 6) whose index equals the register address, in the next bus cycle. The bit clears once the value has reached the functional domain.
- R6: A write to a posted register whose PEND bit is still set is dropped, so the value read back from that register is unchanged.
- R7: Writing 1 to status bit0 clears it. Writing 0 has no effect. An overflow that arrives in the same cycle as the clear wins.
- R8: ENABLE (address 5, bit0) gates the interrupt: `irq` is high exactly when both the status bit and the enable bit are set.
- R9: Reading COUNT returns a continuously refreshed copy of the running count. Started from zero with auto-reload and a reload value of zero, the count free-runs and reads back strictly increasing.
- R10: CTRL bit0 reads back the live run state, including the clear made by a one-shot overflow. CTRL bit1 reads back the written auto-reload setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register bus clock |
| fnClk | input | 1 | Functional (counting) clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| busWe | input | 1 | Write strobe, sampled on busClk |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irq | output | 1 | Overflow interrupt, status AND enable |

## Verification
On every cycle, the assertions check the counter's step, reload, one-shot stop and freeze rules in the functional domain. On the bus side they check that pending bits set, that writes to a busy register are dropped, that the write-one-to-clear status works, that status is set only by a crossed overflow, and that the handshake delivers one strobe per transfer. Some behaviour spans both clock domains and only the bench scenarios can show it: the end-to-end delay from a start write to the interrupt for several loads, periodic re-arming after a clear, the freeze after a stop, and the free-running readback.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  localparam int unsigned CNT_W       = 32;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned CTRL_W      = 2;
  localparam int unsigned NUM_POSTED  = 3;
  localparam int unsigned SYNC_STAGES = 2;

  // Posted registers sit at addresses equal to their pending-bit index.
  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_LOAD   = 3'd1,
    A_COUNT  = 3'd2,
    A_STATUS = 3'd4,
    A_ENABLE = 3'd5,
    A_PEND   = 3'd6
  } regAddr_e;

  // Strobes from the crossing logic into the functional-domain datapath.
  typedef struct packed {
    logic             setCtrl;
    logic             setLoad;
    logic             setCount;
    logic             run;
    logic             autoReload;
    logic [CNT_W-1:0] loadVal;
    logic [CNT_W-1:0] countVal;
  } fnStrobe_t;
endpackage

// File: rtl/ovf_post_sync.sv
// Toggle handshake: the source holds the data and flips a request;
// the destination sees the flip, takes the data and flips an acknowledge.
module ovf_post_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         srcClk,
  input  logic         rstN,
  input  logic         srcLoad,
  input  logic [W-1:0] srcData,
  output logic         busy,
  output logic [W-1:0] heldData,
  input  logic         dstClk,
  output logic         dstStrobe
);
  logic              reqTog;
  logic              ackTog;
  logic [STAGES-1:0] reqPipe;
  logic [STAGES-1:0] ackPipe;

  assign busy      = reqTog ^ ackPipe[STAGES-1];
  assign dstStrobe = reqPipe[STAGES-1] ^ ackTog;

  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) begin
      reqTog   <= 1'b0;
      heldData <= '0;
      ackPipe  <= '0;
    end else begin
      ackPipe <= {ackPipe[STAGES-2:0], ackTog};
      if (srcLoad && !busy) begin
        heldData <= srcData;
        reqTog   <= ~reqTog;
      end
    end
  end

  always_ff @(posedge dstClk or negedge rstN) begin
    if (!rstN) begin
      reqPipe <= '0;
      ackTog  <= 1'b0;
    end else begin
      reqPipe <= {reqPipe[STAGES-2:0], reqTog};
      if (dstStrobe) ackTog <= reqPipe[STAGES-1];
    end
  end

  // One transfer yields exactly one destination strobe (R5).
  p_one_pulse_r5: assert property (@(posedge dstClk) disable iff (!rstN)
    dstStrobe |=> !dstStrobe)
    else $error("p_one_pulse_r5");
endmodule

// File: rtl/ovf_timer_ctrl.sv
// Bus-side register file plus all clock-domain crossings.
module ovf_timer_ctrl
  import ovf_timer_pkg::*;
(
  input  logic              busClk,
  input  logic              fnClk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irq,
  output fnStrobe_t         strobe,
  input  logic [CNT_W-1:0]  fnCount,
  input  logic              fnRun,
  input  logic              fnOvfTog
);
  localparam int unsigned SNAP_W = CNT_W + 1;

  logic [NUM_POSTED-1:0] accept;
  logic [NUM_POSTED-1:0] pend;
  logic [NUM_POSTED-1:0] xStrb;
  logic [CTRL_W-1:0]     heldCtrl;
  logic [CNT_W-1:0]      heldWide [1:NUM_POSTED-1];

  logic                  snapBusy;
  logic                  snapStb;
  logic [SNAP_W-1:0]     snapData;
  logic                  runLive;
  logic [CNT_W-1:0]      countLive;

  logic [SYNC_STAGES-1:0] ovfPipe;
  logic                   ovfPrev;
  logic                   ovfEvt;
  logic                   statusReg;
  logic                   enableReg;
  logic                   clrReq;

  always_comb begin
    for (int i = 0; i < NUM_POSTED; i++)
      accept[i] = busWe && (busAddr == ADDR_W'(i)) && !pend[i];
  end

  for (genvar i = 0; i < NUM_POSTED; i++) begin : g_post
    if (i == 0) begin : g_narrow
      ovf_post_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
        .srcClk   (busClk),
        .rstN     (rstN),
        .srcLoad  (accept[i]),
        .srcData  (busWdata[CTRL_W-1:0]),
        .busy     (pend[i]),
        .heldData (heldCtrl),
        .dstClk   (fnClk),
        .dstStrobe(xStrb[i])
      );
    end else begin : g_wide
      ovf_post_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .srcClk   (busClk),
        .rstN     (rstN),
        .srcLoad  (accept[i]),
        .srcData  (busWdata),
        .busy     (pend[i]),
        .heldData (heldWide[i]),
        .dstClk   (fnClk),
        .dstStrobe(xStrb[i])
      );
    end

    // An accepted posted write marks its register pending (R5).
    p_post_set_r5: assert property (@(posedge busClk) disable iff (!rstN)
      accept[i] |=> pend[i])
      else $error("p_post_set_r5");
  end

  always_comb begin
    strobe.setCtrl    = xStrb[A_CTRL];
    strobe.run        = heldCtrl[0];
    strobe.autoReload = heldCtrl[1];
    strobe.setLoad    = xStrb[A_LOAD];
    strobe.loadVal    = heldWide[A_LOAD];
    strobe.setCount   = xStrb[A_COUNT];
    strobe.countVal   = heldWide[A_COUNT];
  end

  // Continuous copy of run state and count back into the bus domain.
  ovf_post_sync #(.W(SNAP_W), .STAGES(SYNC_STAGES)) u_snap (
    .srcClk   (fnClk),
    .rstN     (rstN),
    .srcLoad  (!snapBusy),
    .srcData  ({fnRun, fnCount}),
    .busy     (snapBusy),
    .heldData (snapData),
    .dstClk   (busClk),
    .dstStrobe(snapStb)
  );

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      runLive   <= 1'b0;
      countLive <= '0;
    end else if (snapStb) begin
      runLive   <= snapData[CNT_W];
      countLive <= snapData[CNT_W-1:0];
    end
  end

  // Overflow toggle crossing and interrupt status.
  assign ovfEvt = ovfPipe[SYNC_STAGES-1] ^ ovfPrev;
  assign clrReq = busWe && (busAddr == A_STATUS) && busWdata[0];

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      ovfPipe   <= '0;
      ovfPrev   <= 1'b0;
      statusReg <= 1'b0;
      enableReg <= 1'b0;
    end else begin
      ovfPipe <= {ovfPipe[SYNC_STAGES-2:0], fnOvfTog};
      ovfPrev <= ovfPipe[SYNC_STAGES-1];
      if (ovfEvt)      statusReg <= 1'b1;
      else if (clrReq) statusReg <= 1'b0;
      if (busWe && (busAddr == A_ENABLE)) enableReg <= busWdata[0];
    end
  end

  assign irq = statusReg & enableReg;

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_CTRL:   begin busRdata[0] = runLive; busRdata[1] = heldCtrl[1]; end
      A_LOAD:   busRdata = heldWide[A_LOAD];
      A_COUNT:  busRdata = countLive;
      A_STATUS: busRdata[0] = statusReg;
      A_ENABLE: busRdata[0] = enableReg;
      A_PEND:   busRdata[NUM_POSTED-1:0] = pend;
      default:  busRdata = '0;
    endcase
  end

  // A write to a busy LOAD leaves the held value alone (R6).
  p_drop_busy_r6: assert property (@(posedge busClk) disable iff (!rstN)
    (busWe && (busAddr == A_LOAD) && pend[A_LOAD]) |=> $stable(heldWide[A_LOAD]))
    else $error("p_drop_busy_r6");

  // Write-one clears status when no overflow lands at the same time (R7).
  p_w1c_r7: assert property (@(posedge busClk) disable iff (!rstN)
    (clrReq && !ovfEvt) |=> !statusReg)
    else $error("p_w1c_r7");

  // Status only rises after a crossed overflow event (R3).
  p_status_src_r3: assert property (@(posedge busClk) disable iff (!rstN)
    $rose(statusReg) |-> $past(ovfEvt))
    else $error("p_status_src_r3");
endmodule

// File: rtl/ovf_timer_core.sv
// Functional-clock datapath: counter, reload value, run and reload flags.
module ovf_timer_core
  import ovf_timer_pkg::*;
(
  input  logic             fnClk,
  input  logic             rstN,
  input  fnStrobe_t        strobe,
  output logic [CNT_W-1:0] count,
  output logic             run,
  output logic             ovfTog
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             autoReload;
  logic [CNT_W-1:0] loadVal;
  logic             atMax;

  assign atMax = run && (count == CNT_MAX);

  always_ff @(posedge fnClk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      run        <= 1'b0;
      autoReload <= 1'b0;
      loadVal    <= '0;
      ovfTog     <= 1'b0;
    end else begin
      if (strobe.setCount)  count <= strobe.countVal;
      else if (atMax)       count <= autoReload ? loadVal : '0;
      else if (run)         count <= count + 1'b1;

      if (strobe.setCtrl)   run <= strobe.run;
      else if (atMax && !autoReload) run <= 1'b0;

      if (strobe.setCtrl)   autoReload <= strobe.autoReload;
      if (strobe.setLoad)   loadVal    <= strobe.loadVal;
      if (atMax)            ovfTog     <= ~ovfTog;
    end
  end

  // Step by one per tick while running (R2).
  p_step_r2: assert property (@(posedge fnClk) disable iff (!rstN)
    (run && !strobe.setCount && (count != CNT_MAX)) |=> (count == $past(count) + 1'b1))
    else $error("p_step_r2");

  // Stopped counter holds its value (R2).
  p_freeze_r2: assert property (@(posedge fnClk) disable iff (!rstN)
    (!run && !strobe.setCount) |=> $stable(count))
    else $error("p_freeze_r2");

  // Periodic overflow reloads from the reload value (R4).
  p_reload_r4: assert property (@(posedge fnClk) disable iff (!rstN)
    (atMax && autoReload && !strobe.setCount && !strobe.setLoad && !strobe.setCtrl)
      |=> (run && (count == $past(loadVal))))
    else $error("p_reload_r4");

  // One-shot overflow wraps to zero and stops (R4).
  p_oneshot_r4: assert property (@(posedge fnClk) disable iff (!rstN)
    (atMax && !autoReload && !strobe.setCount && !strobe.setCtrl) |=> (!run && (count == '0)))
    else $error("p_oneshot_r4");
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
(
  input  logic              busClk,
  input  logic              fnClk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irq
);
  fnStrobe_t        strobe;
  logic [CNT_W-1:0] fnCount;
  logic             fnRun;
  logic             fnOvfTog;

  ovf_timer_ctrl u_ctrl (
    .busClk  (busClk),
    .fnClk   (fnClk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .irq     (irq),
    .strobe  (strobe),
    .fnCount (fnCount),
    .fnRun   (fnRun),
    .fnOvfTog(fnOvfTog)
  );

  ovf_timer_core u_core (
    .fnClk (fnClk),
    .rstN  (rstN),
    .strobe(strobe),
    .count (fnCount),
    .run   (fnRun),
    .ovfTog(fnOvfTog)
  );
endmodule

// File: tb/tb_ovf_timer.sv
module tb_ovf_timer;
  import ovf_timer_pkg::*;

  localparam logic [31:0] MAXV = '1;
  localparam int NV = 6;
  localparam logic [31:0] VEC_N  [NV] = '{32'd3, 32'd5, 32'd17, 32'd40, 32'd9, 32'd3};
  localparam logic        VEC_AR [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  logic        busClk = 1'b0;
  logic        fnClk  = 1'b0;
  logic        rstN   = 1'b0;
  logic        busWe  = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  int fnTicks = 0;

  always #5  busClk = ~busClk;
  always #20 fnClk  = ~fnClk;
  always @(posedge fnClk) fnTicks <= fnTicks + 1;

  ovf_timer dut (
    .busClk(busClk), .fnClk(fnClk), .rstN(rstN), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge busClk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge busClk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge busClk);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitIdle(output bit ok);
    logic [31:0] p;
    ok = 1'b0;
    for (int k = 0; k < 80; k++) begin
      busRead(A_PEND, p);
      if (p[2:0] == 3'b000) begin ok = 1'b1; break; end
    end
  endtask

  task automatic waitIrq(input int limit, output int dt);
    int t0;
    t0 = fnTicks;
    while (!irq && (fnTicks - t0) < limit) @(negedge busClk);
    dt = fnTicks - t0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge busClk);
  endtask

  // One table vector: program all-ones minus N, start, measure, inspect.
  task automatic runVector(input logic [31:0] n, input logic ar);
    logic [31:0] r;
    bit ok;
    int dt;
    busWrite(A_CTRL, 32'd0);
    waitIdle(ok);
    busWrite(A_STATUS, 32'd1);
    busWrite(A_LOAD, ar ? (MAXV - n) : 32'd0);
    busWrite(A_COUNT, MAXV - n);
    waitIdle(ok);
    check(ok, "R5 pending clears", ok, 1);
    busWrite(A_CTRL, {30'd0, ar, 1'b1});
    waitIrq(int'(n) + 40, dt);
    check(irq && dt >= int'(n) + 1 && dt <= int'(n) + 8, "R3 delay to irq", dt, n + 1);
    if (!ar) begin
      settle(30);
      busRead(A_COUNT, r);
      check(r == 32'd0, "R4 one-shot wraps to zero", r, 0);
      busRead(A_CTRL, r);
      check(r[0] == 1'b0, "R10 one-shot clears run", r[0], 0);
    end else begin
      busRead(A_CTRL, r);
      check(r[1:0] == 2'b11, "R10 periodic still running", r[1:0], 3);
      busWrite(A_STATUS, 32'd1);
      waitIrq(int'(n) + 8, dt);
      check(irq == 1'b1, "R4 periodic reload re-arms", irq, 1);
      busWrite(A_CTRL, 32'd0);
      waitIdle(ok);
    end
  endtask

  initial begin
    repeat (400000) @(posedge busClk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] r, a, b, c, d;
    bit ok;
    repeat (3) @(posedge fnClk);
    @(negedge busClk);
    rstN = 1'b1;

    // R1: reset state
    check(irq == 1'b0, "R1 irq low", irq, 0);
    foreach (VEC_AR[k]) begin end
    busRead(A_CTRL, r);   check(r == 0, "R1 ctrl zero", r, 0);
    busRead(A_LOAD, r);   check(r == 0, "R1 load zero", r, 0);
    busRead(A_COUNT, r);  check(r == 0, "R1 count zero", r, 0);
    busRead(A_STATUS, r); check(r == 0, "R1 status zero", r, 0);
    busRead(A_ENABLE, r); check(r == 0, "R1 enable zero", r, 0);
    busRead(A_PEND, r);   check(r == 0, "R1 pend zero", r, 0);

    // R5 pending bit, R6 drop while pending
    busWrite(A_LOAD, 32'h0000_1234);
    busRead(A_PEND, r);
    check(r[2:0] == 3'b010, "R5 load pending set", r[2:0], 2);
    busWrite(A_LOAD, 32'h0000_5678);
    waitIdle(ok);
    check(ok, "R5 pending clears", ok, 1);
    busRead(A_LOAD, r);
    check(r == 32'h0000_1234, "R6 busy write dropped", r, 32'h1234);

    busWrite(A_ENABLE, 32'd1);

    // Table-driven delay vectors (R3, R4, R10)
    for (int k = 0; k < NV; k++) runVector(VEC_N[k], VEC_AR[k]);

    // Status with enable low, stepping, freeze on stop
    busWrite(A_ENABLE, 32'd0);
    busWrite(A_CTRL, 32'd0);
    waitIdle(ok);
    busWrite(A_STATUS, 32'd1);
    busWrite(A_LOAD, 32'd0);
    busWrite(A_COUNT, MAXV - 32'd10);
    waitIdle(ok);
    busWrite(A_CTRL, 32'd3);
    settle(120);
    busRead(A_STATUS, r);
    check(r[0] == 1'b1, "R3 overflow sets status", r[0], 1);
    check(irq == 1'b0, "R8 irq masked", irq, 0);
    busRead(A_COUNT, a);
    settle(20);
    busRead(A_COUNT, b);
    check(b > a && (b - a) >= 3 && (b - a) <= 8, "R2 one step per tick", b - a, 5);
    busWrite(A_CTRL, 32'd0);
    waitIdle(ok);
    settle(20);
    busRead(A_COUNT, c);
    settle(40);
    busRead(A_COUNT, d);
    check(c == d, "R2 stopped count frozen", d, c);
    busRead(A_STATUS, r);
    check(r[0] == 1'b1, "R2 stop keeps status", r[0], 1);
    busRead(A_CTRL, r);
    check(r[0] == 1'b0, "R10 stop reads back", r[0], 0);
    busWrite(A_ENABLE, 32'd1);
    check(irq == 1'b1, "R8 irq when enabled", irq, 1);
    busWrite(A_STATUS, 32'd0);
    busRead(A_STATUS, r);
    check(r[0] == 1'b1, "R7 write zero ignored", r[0], 1);
    busWrite(A_STATUS, 32'd1);
    busRead(A_STATUS, r);
    check(r[0] == 1'b0, "R7 write one clears", r[0], 0);
    check(irq == 1'b0, "R8 irq drops with status", irq, 0);

    // R9: free-running readback
    busWrite(A_LOAD, 32'd0);
    busWrite(A_COUNT, 32'd0);
    busWrite(A_CTRL, 32'd3);
    waitIdle(ok);
    settle(10);
    busRead(A_COUNT, a);
    settle(30);
    busRead(A_COUNT, b);
    settle(30);
    busRead(A_COUNT, c);
    check(b > a && c > b, "R9 free-running increases", c, b);
    busRead(A_CTRL, r);
    check(r[1:0] == 2'b11, "R10 ctrl readback", r[1:0], 3);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule